// File: doc/BRIEF.md
# Shared Interrupt Aggregation Controller

This block merges three groups of peripheral interrupt sources into one CPU interrupt line per group. The groups are three timers, thirty-two general-purpose input pins and sixteen DMA channels (four controllers of four channels each). For each source the block keeps a sticky secondary flag, so that an interrupt service routine can read which source fired and clear it by writing 1.

Each CPU line is a registered copy of "some enabled secondary flag is pending". The line is forced low while the CPU reports that it is acknowledging or running the routine for that group. When the acknowledge input drops, the line is evaluated again on the next clock. Software can therefore clear one source per pass and be interrupted again at once for the rest. The pin and DMA groups have per-source enables. The timers are always enabled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every secondary flag register, every enable register and all three CPU lines read 0.
- R2: A one-cycle pulse on a timer event input sets bit n of the timer flag register (offset 0x00, bit n = timer n). The bit stays set until a write of 1 to that bit clears it. Writing 0 to a bit leaves it unchanged.
- R3: Events arriving on several sources in the same cycle set all of their flag bits together.
- R4: When an event and a write-1-to-clear hit the same flag bit in the same cycle, the bit ends up set.
- R5: A pin event latches only when that pin's enable bit is 1 in that cycle. Pins 0 to 15 have their enables at offset 0x04 bits 15:0 and their flags at 0x0C bits 15:0. Pins 16 to 31 have their enables at 0x08 and their flags at 0x10, where bit k means pin 16+k.
- R6: A DMA event latches only when its enable bit is 1. Controller c, channel h maps to bit 4*c+h of the enable register (offset 0x14) and of the flag register (offset 0x18).
- R7: A CPU line (irq_tmr, irq_gpio, irq_dma) goes high on the clock edge after its group has a flag that is both set and enabled. It goes low on the edge after its isr_ack bit (bit 0 timer, bit 1 pins, bit 2 DMA) is sampled high, and it stays low while that bit is high.
- R8: On the first edge at which isr_ack is sampled low again, the line goes high if an enabled flag is still pending. If none is pending, the line stays low until a new event is latched.
- R9: Reads are combinational from bus_addr. Offsets 0x00 to 0x18 return the current flag or enable values, zero-extended. Any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| tmr_evt | input | 3 | Timer expiry pulses |
| gpio_evt | input | 32 | Pin interrupt pulses |
| dma_evt | input | 16 | DMA channel pulses, bit 4*controller+channel |
| isr_ack | input | 3 | Routine active or acknowledge per group: timer, pins, DMA |
| irq_tmr | output | 1 | CPU line for the timer group |
| irq_gpio | output | 1 | CPU line for the pin group |
| irq_dma | output | 1 | CPU line for the DMA group |

## Verification
The bench targets the case where an event and its own clear arrive in the same cycle. A design that gave priority to the clear would lose that interrupt for good. It also clears one of two pending timer flags during the routine and checks that the line comes back on the edge after acknowledge drops. A design that required a fresh edge to raise the line would leave the second source unserviced. It fires pin and DMA sources while they are disabled, and it masks a pin that is already flagged. A design that latched without its enable, or that ignored the enable when building the line, would give a wrong flag read-back or a stray interrupt. A behavioural model under random traffic also checks every cycle that the lines are held low during acknowledge and that writes of 0 clear nothing.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int AW = 5;
  localparam int BW = 16;
  localparam logic [AW-1:0] A_TFLG    = 5'h00;
  localparam logic [AW-1:0] A_GEN_LO  = 5'h04;
  localparam logic [AW-1:0] A_GEN_HI  = 5'h08;
  localparam logic [AW-1:0] A_GFLG_LO = 5'h0C;
  localparam logic [AW-1:0] A_GFLG_HI = 5'h10;
  localparam logic [AW-1:0] A_DEN     = 5'h14;
  localparam logic [AW-1:0] A_DFLG    = 5'h18;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 4,
  parameter logic [W-1:0] EN_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] en_mask,
  input  logic [W-1:0] en_data,
  output logic [W-1:0] flags,
  output logic [W-1:0] en,
  output logic         pending
);
  logic [W-1:0] take;

  function automatic logic [W-1:0] w1c_next(input logic [W-1:0] cur,
                                            input logic [W-1:0] clr,
                                            input logic [W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [W-1:0] masked_write(input logic [W-1:0] cur,
                                                input logic [W-1:0] msk,
                                                input logic [W-1:0] dat);
    return (cur & ~msk) | (dat & msk);
  endfunction

  assign take    = evt & en;
  assign pending = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= EN_RST;
    end else begin
      flags <= w1c_next(flags, clr_mask, take);
      en    <= masked_write(en, en_mask, en_data);
    end
  end

  // R4
  take_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|take) |=> ((flags & $past(take)) == $past(take)));
  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(take)) == '0));
  // R2
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags & $past(flags) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/irq_cpu_line.sv
module irq_cpu_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic ack,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending & ~ack;
  end

  // R7
  ack_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  // R8
  reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && pending) |=> irq);
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_TMR  = 3,
  parameter int N_DCTL = 4,
  parameter int N_DCH  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [BW-1:0]          bus_wdata,
  output logic [BW-1:0]          bus_rdata,
  input  logic [N_TMR-1:0]       tmr_evt,
  input  logic [2*BW-1:0]        gpio_evt,
  input  logic [N_DCTL*N_DCH-1:0] dma_evt,
  input  logic [2:0]             isr_ack,
  output logic                   irq_tmr,
  output logic                   irq_gpio,
  output logic                   irq_dma
);
  localparam int N_GPIO = 2 * BW;
  localparam int N_DMA  = N_DCTL * N_DCH;

  logic [N_TMR-1:0]  t_clr, t_flags, t_en;
  logic [N_GPIO-1:0] g_clr, g_enm, g_end, g_flags, g_en;
  logic [N_DMA-1:0]  d_clr, d_enm, d_end, d_flags, d_en;
  logic              t_pend, g_pend, d_pend;

  function automatic logic hit(input logic wr, input logic [AW-1:0] a,
                               input logic [AW-1:0] target);
    return wr && (a == target);
  endfunction

  assign t_clr = hit(bus_wr, bus_addr, A_TFLG) ? bus_wdata[N_TMR-1:0] : '0;
  assign g_clr = {hit(bus_wr, bus_addr, A_GFLG_HI) ? bus_wdata : {BW{1'b0}},
                  hit(bus_wr, bus_addr, A_GFLG_LO) ? bus_wdata : {BW{1'b0}}};
  assign g_enm = {{BW{hit(bus_wr, bus_addr, A_GEN_HI)}},
                  {BW{hit(bus_wr, bus_addr, A_GEN_LO)}}};
  assign g_end = {bus_wdata, bus_wdata};
  assign d_clr = hit(bus_wr, bus_addr, A_DFLG) ? bus_wdata[N_DMA-1:0] : '0;
  assign d_enm = {N_DMA{hit(bus_wr, bus_addr, A_DEN)}};
  assign d_end = bus_wdata[N_DMA-1:0];

  irq_flag_bank #(.W(N_TMR), .EN_RST({N_TMR{1'b1}})) u_tmr (
    .clk(clk), .rst_n(rst_n), .evt(tmr_evt), .clr_mask(t_clr),
    .en_mask('0), .en_data('0), .flags(t_flags), .en(t_en), .pending(t_pend));

  irq_flag_bank #(.W(N_GPIO)) u_gpio (
    .clk(clk), .rst_n(rst_n), .evt(gpio_evt), .clr_mask(g_clr),
    .en_mask(g_enm), .en_data(g_end), .flags(g_flags), .en(g_en),
    .pending(g_pend));

  irq_flag_bank #(.W(N_DMA)) u_dma (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .clr_mask(d_clr),
    .en_mask(d_enm), .en_data(d_end), .flags(d_flags), .en(d_en),
    .pending(d_pend));

  irq_cpu_line u_line_tmr (.clk(clk), .rst_n(rst_n), .pending(t_pend),
                           .ack(isr_ack[0]), .irq(irq_tmr));
  irq_cpu_line u_line_gpio (.clk(clk), .rst_n(rst_n), .pending(g_pend),
                            .ack(isr_ack[1]), .irq(irq_gpio));
  irq_cpu_line u_line_dma (.clk(clk), .rst_n(rst_n), .pending(d_pend),
                           .ack(isr_ack[2]), .irq(irq_dma));

  always_comb begin
    case (bus_addr)
      A_TFLG:    bus_rdata = BW'(t_flags);
      A_GEN_LO:  bus_rdata = g_en[BW-1:0];
      A_GEN_HI:  bus_rdata = g_en[N_GPIO-1:BW];
      A_GFLG_LO: bus_rdata = g_flags[BW-1:0];
      A_GFLG_HI: bus_rdata = g_flags[N_GPIO-1:BW];
      A_DEN:     bus_rdata = BW'(d_en);
      A_DFLG:    bus_rdata = BW'(d_flags);
      default:   bus_rdata = '0;
    endcase
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > A_DFLG) |-> (bus_rdata == '0));
endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  tmr_evt = '0;
  logic [31:0] gpio_evt = '0;
  logic [15:0] dma_evt = '0;
  logic [2:0]  isr_ack = '0;
  logic        irq_tmr, irq_gpio, irq_dma;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_evt(tmr_evt),
    .gpio_evt(gpio_evt), .dma_evt(dma_evt), .isr_ack(isr_ack),
    .irq_tmr(irq_tmr), .irq_gpio(irq_gpio), .irq_dma(irq_dma));

  always #2 clk = ~clk;

  // behavioural reference state
  logic [2:0]  m_tf;
  logic [31:0] m_gf, m_ge;
  logic [15:0] m_df, m_de;
  logic [2:0]  m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tf = 0; m_gf = 0; m_ge = 0; m_df = 0; m_de = 0; m_irq = 0;
    end else begin
      logic [2:0]  tc;
      logic [31:0] gc, ge_n;
      logic [15:0] dc, de_n;
      tc = 0; gc = 0; dc = 0; ge_n = m_ge; de_n = m_de;
      m_irq[0] = !isr_ack[0] && (m_tf != 0);
      m_irq[1] = !isr_ack[1] && ((m_gf & m_ge) != 0);
      m_irq[2] = !isr_ack[2] && ((m_df & m_de) != 0);
      if (bus_wr) begin
        if (bus_addr == 5'h00) tc = bus_wdata[2:0];
        if (bus_addr == 5'h04) ge_n[15:0] = bus_wdata;
        if (bus_addr == 5'h08) ge_n[31:16] = bus_wdata;
        if (bus_addr == 5'h0C) gc[15:0] = bus_wdata;
        if (bus_addr == 5'h10) gc[31:16] = bus_wdata;
        if (bus_addr == 5'h14) de_n = bus_wdata;
        if (bus_addr == 5'h18) dc = bus_wdata;
      end
      m_tf = (m_tf & ~tc) | tmr_evt;
      m_gf = (m_gf & ~gc) | (gpio_evt & m_ge);
      m_df = (m_df & ~dc) | (dma_evt & m_de);
      m_ge = ge_n;
      m_de = de_n;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return {13'b0, m_tf};
      5'h04: return m_ge[15:0];
      5'h08: return m_ge[31:16];
      5'h0C: return m_gf[15:0];
      5'h10: return m_gf[31:16];
      5'h14: return m_de;
      5'h18: return m_df;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 lines vs model", {29'b0, irq_dma, irq_gpio, irq_tmr}, {29'b0, m_irq});
      chk("R9 read vs model", {16'b0, bus_rdata}, {16'b0, exp_rd(bus_addr)});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(tag, {16'b0, bus_rdata}, {16'b0, e});
    tick();
  endtask

  task automatic expect_irq(input int idx, input logic e, input string tag);
    logic [2:0] v;
    @(negedge clk);
    v = {irq_dma, irq_gpio, irq_tmr};
    chk(tag, {31'b0, v[idx]}, {31'b0, e});
    tick();
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 7; a++) expect_rd(5'(a * 4), 16'h0, "R1 reset register");
    expect_irq(0, 0, "R1 irq_tmr reset");
    expect_irq(1, 0, "R1 irq_gpio reset");
    expect_irq(2, 0, "R1 irq_dma reset");

    // R2 latch, hold, write-0, clear
    tmr_evt = 3'b010; tick(); tmr_evt = 0;
    expect_rd(5'h00, 16'h2, "R2 timer latch");
    expect_irq(0, 1, "R7 timer line rises");
    wr(5'h00, 16'h0);
    expect_rd(5'h00, 16'h2, "R2 write 0 keeps flag");
    isr_ack[0] = 1; tick();
    expect_irq(0, 0, "R7 low during ack");
    wr(5'h00, 16'h2);
    isr_ack[0] = 0; tick(); tick();
    expect_irq(0, 0, "R8 stays low when all cleared");
    expect_rd(5'h00, 16'h0, "R2 write 1 clears");

    // R3 simultaneous, R8 reassert
    tmr_evt = 3'b101; tick(); tmr_evt = 0;
    expect_rd(5'h00, 16'h5, "R3 simultaneous events");
    isr_ack[0] = 1; tick();
    wr(5'h00, 16'h1);
    expect_rd(5'h00, 16'h4, "R2 single clear");
    expect_irq(0, 0, "R7 held during ack");
    isr_ack[0] = 0; tick();
    expect_irq(0, 1, "R8 reassert after ack drop");
    wr(5'h00, 16'h4);

    // R4 event beats clear
    tmr_evt = 3'b100; bus_wr = 1; bus_addr = 5'h00; bus_wdata = 16'h4;
    tick();
    tmr_evt = 0; bus_wr = 0;
    expect_rd(5'h00, 16'h4, "R4 event wins over clear");
    wr(5'h00, 16'h4);
    expect_rd(5'h00, 16'h0, "R2 cleared after R4");

    // R5 pins
    gpio_evt = (32'h1 << 3) | (32'h1 << 20); tick(); gpio_evt = 0;
    expect_rd(5'h0C, 16'h0, "R5 disabled low pin ignored");
    expect_rd(5'h10, 16'h0, "R5 disabled high pin ignored");
    expect_irq(1, 0, "R5 no line when disabled");
    wr(5'h04, 16'h0008);
    wr(5'h08, 16'h0010);
    expect_rd(5'h04, 16'h0008, "R9 low enable readback");
    expect_rd(5'h08, 16'h0010, "R9 high enable readback");
    gpio_evt = (32'h1 << 3) | (32'h1 << 20); tick(); gpio_evt = 0;
    expect_rd(5'h0C, 16'h0008, "R5 pin 3 flag");
    expect_rd(5'h10, 16'h0010, "R5 pin 20 flag");
    expect_irq(1, 1, "R7 pin line");
    wr(5'h04, 16'h0);
    wr(5'h10, 16'h0010);
    tick();
    expect_irq(1, 0, "R7 disabled flag masked");
    expect_rd(5'h0C, 16'h0008, "R9 masked flag still reads");
    wr(5'h0C, 16'h0008);

    // R6 DMA, controller 2 channel 1 -> bit 9
    dma_evt = 16'h0200; tick(); dma_evt = 0;
    expect_rd(5'h18, 16'h0, "R6 disabled channel ignored");
    wr(5'h14, 16'h0200);
    dma_evt = 16'h0200; tick(); dma_evt = 0;
    expect_rd(5'h18, 16'h0200, "R6 channel flag");
    expect_irq(2, 1, "R6 dma line");
    wr(5'h18, 16'h0200);

    // R9 unmapped
    expect_rd(5'h1C, 16'h0, "R9 unmapped offset");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      tmr_evt  = 3'($urandom) & 3'($urandom) & 3'($urandom);
      gpio_evt = $urandom & $urandom & $urandom & $urandom;
      dma_evt  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      bus_wr   = ($urandom % 3) == 0;
      bus_addr = 5'(($urandom % 8) * 4);
      bus_wdata = 16'($urandom);
      for (int g = 0; g < 3; g++) if (($urandom % 6) == 0) isr_ack[g] = ~isr_ack[g];
      tick();
    end
    bus_wr = 0; tmr_evt = 0; gpio_evt = 0; dma_evt = 0; isr_ack = 0;
    tick(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule